// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Level Threshold

This block stores bytes handed over by a serial bus engine until software collects them. It holds up to sixteen bytes in arrival order. The consumer removes the oldest byte by pulsing a read strobe, and the popped byte appears on a data register one cycle later. Status outputs give a zero-based fill level, an empty flag and a full flag.

A threshold register sets the fill level at which a level indication is raised. The value is zero-based: a setting of N asks for N+1 bytes. Software can rewrite the threshold at any time, including while a message is arriving. This lets it ask for a short final tail without having to drain the queue first. A synchronous clear input returns the queue to its initial state without a full reset.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset, empty=1, full=0, occ=0, level_hit=0, overflow=0 and rd_data=0. The threshold resets to 15, which means sixteen bytes.
- R2: Bytes leave in the order they were written. rd_data takes the oldest byte on the clock edge where rd_en is sampled high while the queue is not empty, and holds that value until the next pop.
- R3: empty is 1 exactly when zero bytes are stored, and full is 1 exactly when sixteen bytes are stored.
- R4: occ shows the stored count minus one. It shows 0 when the queue is empty.
- R5: level_hit is 1 exactly when the stored count is at least the threshold value plus one. Threshold values run from 0 to 15.
- R6: When thr_we is sampled high, the threshold takes thr_wdata at that edge. From the following cycle, level_hit is evaluated against the new value, with no extra lag.
- R7: A write sampled while the queue is full is dropped and the stored bytes are unchanged. It sets overflow, which stays at 1 until reset or clear.
- R8: A read sampled while the queue is empty leaves rd_data, occ and the flags unchanged.
- R9: A read and a write in the same cycle, on a queue that is neither empty nor full, leave the count unchanged and keep the order.
- R10: clr sampled high empties the queue, restores the threshold to 15, clears overflow and sets rd_data to 0. It takes priority over any write, read or threshold write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous soft clear |
| wr_en | input | 1 | Push strobe from the bus engine |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop strobe from the data register read |
| rd_data | output | 8 | Most recently popped byte |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 4 | New zero-based threshold |
| occ | output | 4 | Zero-based fill level |
| empty | output | 1 | No bytes stored |
| full | output | 1 | Sixteen bytes stored |
| level_hit | output | 1 | Fill level has reached the threshold |
| overflow | output | 1 | Sticky record of a dropped write |

## Verification
The queue is filled to capacity at a mid threshold and then pushed once more. This separates correct dropping and the sticky overflow from wrap-around overwrite. It is then drained past empty, which shows whether an extra pop disturbs the data register or the pointers. The threshold is rewritten to 0 and to 15 while bytes are held, which checks the zero-based comparison at both ends and shows that there is no lag. Simultaneous read and write traffic, and a clear issued together with a write, test count stability and clear priority.

// File: rtl/rxq_pkg.sv
// Package: shared byte type and helpers for the receive byte queue.
// Assumes the queue depth is a power of two.
package rxq_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxq_store.sv
// Module: rxq_store
// Stores the bytes in a circular array and keeps the head and tail pointers.
// It loads the popped byte into an output register.
// Assumes that push and pop are already qualified against full and empty.
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  rxq_pkg::byte_t    push_data,
    input  logic              pop,
    output rxq_pkg::byte_t    pop_data
);
    rxq_pkg::byte_t     slot [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;

    // One write-enabled register per slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(i))
                slot[i] <= push_data;
        end
    end

    // Pointer advance, wrapping at the depth.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Output register: loads on pop, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pop_data <= '0;
        else if (pop)
            pop_data <= slot[rd_ptr];
    end

    // R8: without a pop, the output byte must not move.
    p_hold_without_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop && !clr) |=> $stable(pop_data));
endmodule

// File: rtl/rxq_level.sv
// Module: rxq_level
// Tracks the stored count and holds the zero-based threshold.
// Derives the fill level, the flags, the level indication and the sticky overflow.
// Assumes that push and pop are qualified by the top-level module.
module rxq_level #(
    parameter int DEPTH   = 16,
    parameter int PTR_W   = $clog2(DEPTH),
    parameter int CNT_W   = PTR_W + 1,
    parameter int THR_RST = DEPTH - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic             drop,
    input  logic             thr_we,
    input  logic [PTR_W-1:0] thr_wdata,
    output logic [PTR_W-1:0] occ,
    output logic             empty,
    output logic             full,
    output logic             level_hit,
    output logic             overflow
);
    logic [CNT_W-1:0] count;
    logic [PTR_W-1:0] thr_q;
    logic [CNT_W-1:0] thr_need;

    // Stored count: up on push, down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (push && !pop)
            count <= count + 1'b1;
        else if (pop && !push)
            count <= count - 1'b1;
    end

    // Threshold register, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            thr_q <= PTR_W'(THR_RST);
        else if (thr_we)
            thr_q <= thr_wdata;
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            overflow <= 1'b0;
        else if (drop)
            overflow <= 1'b1;
    end

    // Status decode from the count and the threshold.
    always_comb begin
        thr_need  = CNT_W'(thr_q) + 1'b1;
        empty     = (count == '0);
        full      = (count == CNT_W'(DEPTH));
        occ       = empty ? '0 : PTR_W'(count - 1'b1);
        level_hit = (count >= thr_need);
    end

    p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    p_thr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_we && !clr) |=> (thr_q == $past(thr_wdata)));
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr) |=> overflow);
    p_clr_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !overflow && thr_q == PTR_W'(THR_RST)));
endmodule

// File: rtl/rx_byte_queue.sv
// Module: rx_byte_queue
// Top level of the receive byte queue. It qualifies the push and pop strobes
// against the flags and joins the storage to the level tracker.
// Assumes a single clock and that the strobes are synchronous to it.
module rx_byte_queue #(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    input  logic             thr_we,
    input  logic [PTR_W-1:0] thr_wdata,
    output logic [PTR_W-1:0] occ,
    output logic             empty,
    output logic             full,
    output logic             level_hit,
    output logic             overflow
);
    logic push;
    logic pop;
    logic drop;

    // Strobe qualification against the flags as they stand at the start of the cycle.
    always_comb begin
        push = wr_en && !full && !clr;
        drop = wr_en && full && !clr;
        pop  = rd_en && !empty && !clr;
    end

    rxq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .pop_data  (rd_data)
    );

    rxq_level #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (push),
        .pop       (pop),
        .drop      (drop),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .occ       (occ),
        .empty     (empty),
        .full      (full),
        .level_hit (level_hit),
        .overflow  (overflow)
    );

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !clr) |=> (full && overflow));
    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en && !clr) |=> (empty && $stable(rd_data)));
    p_rdwr_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && rd_en && wr_en && !clr) |=> $stable(occ));
endmodule

// File: tb/rx_byte_queue_tb.sv
// Bench: a behavioural queue model, compared with the design after every clock.
module rx_byte_queue_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       thr_we = 1'b0;
    logic [3:0] thr_wdata = '0;
    logic [3:0] occ;
    logic       empty, full, level_hit, overflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    byte unsigned mq[$];
    int           m_thr = 15;
    bit           m_ovf = 0;
    int           m_rd  = 0;

    always #5 clk = ~clk;

    rx_byte_queue u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .occ(occ), .empty(empty), .full(full), .level_hit(level_hit),
        .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int n = mq.size();
        chk(empty == (n == 0), "R3 empty", empty, n == 0);
        chk(full == (n == 16), "R3 full", full, n == 16);
        chk(occ == ((n == 0) ? 0 : n - 1), "R4 occ", occ, (n == 0) ? 0 : n - 1);
        chk(level_hit == (n >= m_thr + 1), "R5 level", level_hit, n >= m_thr + 1);
        chk(overflow == m_ovf, "R7 overflow", overflow, m_ovf);
        chk(rd_data == m_rd, "R2 rd_data", rd_data, m_rd);
    endtask

    task automatic step(input bit w, input int wd, input bit r,
                        input bit tw, input int tv, input bit c);
        bit was_full, was_empty;
        wr_en = w; wr_data = 8'(wd); rd_en = r; thr_we = tw; thr_wdata = 4'(tv); clr = c;
        @(posedge clk);
        was_full  = (mq.size() == 16);
        was_empty = (mq.size() == 0);
        if (c) begin
            mq.delete(); m_thr = 15; m_ovf = 0; m_rd = 0;
        end else begin
            if (r && !was_empty) m_rd = mq.pop_front();
            if (w) begin
                if (was_full) m_ovf = 1;
                else mq.push_back(8'(wd));
            end
            if (tw) m_thr = tv;
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0; thr_we = 0; clr = 0;
        compare_all();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(empty && !full && occ == 0 && !level_hit && !overflow && rd_data == 0,
            "R1 reset", {empty, full, level_hit, overflow}, 4'b1000);
        compare_all();

        // Threshold 3, fill to capacity (R5, R3).
        step(0, 0, 0, 1, 3, 0);
        for (int i = 0; i < 16; i++) step(1, 8'h10 + i, 0, 0, 0, 0);
        // R7: push while full is dropped.
        step(1, 8'hEE, 0, 0, 0, 0);
        chk(overflow == 1 && occ == 15, "R7 drop", overflow, 1);
        // R6: threshold rewrites take effect at once.
        step(0, 0, 0, 1, 15, 0);
        chk(level_hit == 1, "R6 thr15 full", level_hit, 1);
        step(1, 8'h55, 1, 0, 0, 0);        // full with read and write: write dropped
        step(0, 0, 1, 1, 0, 0);
        chk(level_hit == 1, "R6 thr0", level_hit, 1);
        // Drain (R2 order).
        for (int i = 0; i < 14; i++) step(0, 0, 1, 0, 0, 0);
        chk(empty == 1, "R2 drained", empty, 1);
        // R8: read on empty.
        step(0, 0, 1, 0, 0, 0);
        chk(rd_data == 8'h1F, "R8 empty read", rd_data, 8'h1F);
        step(0, 0, 1, 0, 0, 0);
        // R9: read and write together at mid level.
        for (int i = 0; i < 5; i++) step(1, 8'hA0 + i, 0, 0, 0, 0);
        step(0, 0, 0, 1, 4, 0);
        for (int i = 0; i < 6; i++) step(1, 8'hB0 + i, 1, 0, 0, 0);
        chk(occ == 4, "R9 steady", occ, 4);
        // R6: a mid-message threshold change flips the level.
        step(0, 0, 0, 1, 5, 0);
        chk(level_hit == 0, "R6 raise", level_hit, 0);
        // R10: clear beats write and threshold write.
        step(1, 8'h77, 1, 1, 2, 1);
        chk(empty && !overflow && rd_data == 0, "R10 clear", empty, 1);
        step(1, 8'h01, 0, 0, 0, 0);
        for (int i = 0; i < 15; i++) step(1, i, 0, 0, 0, 0);
        chk(level_hit == 1 && full == 1, "R10 thr restored", level_hit, 1);
        for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule